// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block guards a system against a stalled program. A free-running counter advances on one of two clock-enable inputs. A program must restart that counter before it reaches the selected interval. If the program fails to do so in watchdog mode, the block emits a one-cycle reset pulse. In interval mode the same expiry sets an interrupt flag instead, and the counter keeps running, so the block serves as a periodic tick source.

All control sits in one 16-bit word register. Every write must carry a key in its upper byte. A write that carries any other upper byte is treated as a runaway program and triggers the reset pulse at once. Reads return a fixed key of a different value in the upper byte, so a value that was read back cannot simply be written again.

The block wakes up running. With the enable ticking at 1 MHz, the default interval ends about 32 ms after power-up.

Top module: `wdog_keyed`

## Requirements
- R1: After power-up, and in the cycle the reset pulse is high, a read returns 0x6900. This means watchdog mode, counter running, tap encoding 0, enable A selected, no reset pulse and no flag.
- R2: A write (`bus_sel` and `bus_we` high) whose bits 15:8 equal 0x5A updates the control fields. A write with any other upper byte leaves the fields alone and raises `wdt_rst` on the next cycle.
- R3: The read word is laid out as follows:
  - bits 15:8 hold the constant 0x69;
  - bit 7 is hold;
  - bit 4 is interval mode;
  - bit 2 is clock select;
  - bits 1:0 are the tap encoding;
  - bit 3 and every other bit read 0, and bits 6 and 5 of a write are ignored.
- R4: In watchdog mode, `wdt_rst` is high for exactly one cycle. It rises on the edge of the tick that completes the interval. The fields return to their defaults and the count restarts from zero on that same edge.
- R5: While bit 7 (hold) is 1, ticks do not advance the count. After hold is released, counting resumes from the frozen value.
- R6: A keyed write with bit 3 set restarts the count from zero. The bit is not stored.
- R7: The tap encoding sets the interval in ticks: 0 gives 32768, 1 gives 8192, 2 gives 512, 3 gives 64.
- R8: In interval mode (bit 4 = 1), expiry sets `irq_flag` and does not raise `wdt_rst`. The counter keeps going, so the flag recurs every interval. A one-cycle `irq_ack` clears the flag.
- R9: With bit 2 = 0 the counter advances on `clk_en_a`; with bit 2 = 1 it advances on `clk_en_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| clk_en_a | input | 1 | Count enable, source A |
| clk_en_b | input | 1 | Count enable, source B |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_wdata | input | 16 | Write word, key in bits 15:8 |
| bus_rdata | output | 16 | Read word, read key in bits 15:8 |
| irq_ack | input | 1 | Clears the interval flag |
| wdt_rst | output | 1 | One-cycle reset request |
| irq_flag | output | 1 | Interval-mode expiry flag |

## Verification
The single-cycle property for `wdt_rst` assumes the bus never issues two wrongly keyed writes on consecutive cycles. The bench always leaves an idle cycle between writes, which keeps it within that assumption. The hold property assumes hold is only released by a keyed write. The bench therefore drives both enables low around every write, so no tick lands on the edge where a field changes. With that rule in place, interval lengths can be counted exactly from the write that cleared the counter.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam int unsigned ISEL_W = 2;
   localparam int unsigned NTAP   = 1 << ISEL_W;

   // stored control fields
   typedef struct packed {
      logic              hold;
      logic              tmode;
      logic              csel;
      logic [ISEL_W-1:0] isel;
   } wdog_ctl_t;

   localparam wdog_ctl_t CTL_DEFAULT = '0;

   // bit positions of the word view
   localparam int unsigned B_HOLD  = 7;
   localparam int unsigned B_TMODE = 4;
   localparam int unsigned B_CLR   = 3;
   localparam int unsigned B_CSEL  = 2;

   function automatic int unsigned tap_max(input int unsigned t [NTAP]);
      int unsigned m;
      m = 0;
      for (int i = 0; i < NTAP; i++) if (t[i] > m) m = t[i];
      return m;
   endfunction

endpackage

// File: rtl/wdog_ctl_reg.sv
module wdog_ctl_reg
   import wdog_pkg::*;
#(
   parameter logic [7:0] WKEY = 8'h5A,
   parameter logic [7:0] RKEY = 8'h69
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sys_clr,
   input  logic        bus_sel,
   input  logic        bus_we,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   output wdog_ctl_t   ctl,
   output logic        clr_req,
   output logic        key_bad
);

   logic      wr, key_ok, wr_ok;
   wdog_ctl_t ctl_d;
   logic      unused_wbits;

   assign wr      = bus_sel & bus_we;
   assign key_ok  = (bus_wdata[15:8] == WKEY);
   assign wr_ok   = wr & key_ok;
   assign key_bad = wr & ~key_ok;
   assign clr_req = wr_ok & bus_wdata[B_CLR];

   assign unused_wbits = ^{bus_wdata[6:5]};

   always_comb begin
      ctl_d       = ctl;
      ctl_d.hold  = bus_wdata[B_HOLD];
      ctl_d.tmode = bus_wdata[B_TMODE];
      ctl_d.csel  = bus_wdata[B_CSEL];
      ctl_d.isel  = bus_wdata[ISEL_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctl <= CTL_DEFAULT;
      else if (sys_clr) ctl <= CTL_DEFAULT;
      else if (wr_ok)   ctl <= ctl_d;
   end

   always_comb begin
      bus_rdata                = '0;
      bus_rdata[15:8]          = RKEY;
      bus_rdata[B_HOLD]        = ctl.hold;
      bus_rdata[B_TMODE]       = ctl.tmode;
      bus_rdata[B_CSEL]        = ctl.csel;
      bus_rdata[ISEL_W-1:0]    = ctl.isel;
   end

   // R6
   clr_not_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[B_CLR] == 1'b0);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
   import wdog_pkg::*;
#(
   parameter int unsigned TAP_LOG2 [NTAP] = '{15, 13, 9, 6},
   parameter int unsigned CNT_W = tap_max(TAP_LOG2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sys_clr,
   input  logic              clr_req,
   input  logic              hold,
   input  logic              tick,
   input  logic [ISEL_W-1:0] isel,
   output logic              expire
);

   logic [CNT_W-1:0] count_q;
   logic [NTAP-1:0]  tap_hit;
   logic             adv;

   for (genvar i = 0; i < NTAP; i++) begin : g_tap
      if (TAP_LOG2[i] < 1 || TAP_LOG2[i] > CNT_W)
         $error("tap %0d width out of range", i);
      assign tap_hit[i] = &count_q[TAP_LOG2[i]-1:0];
   end

   assign adv    = tick & ~hold;
   // a service write in the same cycle wins over expiry
   assign expire = adv & tap_hit[isel] & ~clr_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 count_q <= '0;
      else if (sys_clr | clr_req) count_q <= '0;
      else if (adv)               count_q <= count_q + CNT_W'(1);
   end

   // R5
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !clr_req && !sys_clr) |=> (count_q == $past(count_q)));

   // R6
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |=> (count_q == '0));

endmodule

// File: rtl/wdog_event.sv
module wdog_event (
   input  logic clk,
   input  logic rst_n,
   input  logic key_bad,
   input  logic expire,
   input  logic tmode,
   input  logic irq_ack,
   output logic sys_clr,
   output logic rst_pulse,
   output logic irq_flag
);

   assign sys_clr = key_bad | (expire & ~tmode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_pulse <= 1'b0;
         irq_flag  <= 1'b0;
      end else begin
         rst_pulse <= sys_clr;
         if (sys_clr)               irq_flag <= 1'b0;
         else if (expire && tmode)  irq_flag <= 1'b1;
         else if (irq_ack)          irq_flag <= 1'b0;
      end
   end

   // R4
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |=> !rst_pulse);

   // R8
   interval_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && tmode && !key_bad) |=> (irq_flag && !rst_pulse));

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
   import wdog_pkg::*;
#(
   parameter logic [7:0]  WKEY = 8'h5A,
   parameter logic [7:0]  RKEY = 8'h69,
   parameter int unsigned TAP_LOG2 [NTAP] = '{15, 13, 9, 6}
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clk_en_a,
   input  logic        clk_en_b,
   input  logic        bus_sel,
   input  logic        bus_we,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   input  logic        irq_ack,
   output logic        wdt_rst,
   output logic        irq_flag
);

   localparam int unsigned CNT_W = tap_max(TAP_LOG2);

   if (WKEY == RKEY) $error("read key must differ from write key");

   wdog_ctl_t ctl;
   logic      clr_req, key_bad, expire, sys_clr, tick;

   assign tick = ctl.csel ? clk_en_b : clk_en_a;

   wdog_ctl_reg #(.WKEY(WKEY), .RKEY(RKEY)) u_reg (
      .clk, .rst_n, .sys_clr, .bus_sel, .bus_we, .bus_wdata,
      .bus_rdata, .ctl, .clr_req, .key_bad
   );

   wdog_counter #(.TAP_LOG2(TAP_LOG2), .CNT_W(CNT_W)) u_cnt (
      .clk, .rst_n, .sys_clr, .clr_req,
      .hold(ctl.hold), .tick, .isel(ctl.isel), .expire
   );

   wdog_event u_evt (
      .clk, .rst_n, .key_bad, .expire, .tmode(ctl.tmode), .irq_ack,
      .sys_clr, .rst_pulse(wdt_rst), .irq_flag
   );

   // R2
   bad_key_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && bus_wdata[15:8] != WKEY) |=> wdt_rst);

   // R1
   default_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst |-> (bus_rdata == {RKEY, 8'h00}));

endmodule

// File: tb/sim_wdog_keyed.sv
`timescale 1ns/1ps
module sim_wdog_keyed;

   logic        clk = 0, rst_n = 0;
   logic        clk_en_a = 0, clk_en_b = 0;
   logic        bus_sel = 0, bus_we = 0, irq_ack = 0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        wdt_rst, irq_flag;

   int  vec_cnt = 0, err_cnt = 0;
   bit  done = 0, tb_on = 0;
   int  tb_div = 0;

   wdog_keyed u0 (
      .clk, .rst_n, .clk_en_a, .clk_en_b, .bus_sel, .bus_we,
      .bus_wdata, .bus_rdata, .irq_ack, .wdt_rst, .irq_flag
   );

   initial forever #2.5 clk = ~clk;

   // enable B: one pulse every 4 cycles while tb_on
   initial forever begin
      @(negedge clk);
      tb_div   = (tb_div + 1) % 4;
      clk_en_b = tb_on && (tb_div == 0);
   end

   // {write word, expected read word, expected reset}
   localparam logic [32:0] VEC [8] = '{
      {16'h5A80, 16'h6980, 1'b0},   // R3 hold bit
      {16'h5A13, 16'h6913, 1'b0},   // R3 mode + tap
      {16'h5A0E, 16'h6906, 1'b0},   // R6 clear not stored
      {16'h5A97, 16'h6997, 1'b0},   // R3 all fields
      {16'h1297, 16'h6900, 1'b1},   // R2 bad key
      {16'h5A66, 16'h6906, 1'b0},   // R3 bits 6,5 ignored
      {16'h5A95, 16'h6995, 1'b0},   // R2 good key
      {16'h5B00, 16'h6900, 1'b1}    // R2 near-miss key
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vec_cnt++;
      if (act !== exp) begin
         err_cnt++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] w);
      @(negedge clk);
      bus_sel = 1; bus_we = 1; bus_wdata = w;
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
   endtask

   task automatic run_until(input int limit, output int n, output logic s_rst, output logic s_flag);
      n = 0; s_rst = 0; s_flag = 0;
      while (n < limit && !s_rst && !s_flag) begin
         @(negedge clk);
         n++;
         s_rst  = wdt_rst;
         s_flag = irq_flag;
      end
   endtask

   task automatic ack();
      irq_ack = 1;
      @(negedge clk);
      irq_ack = 0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         err_cnt++;
         $display("FAIL watchdog: run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
         $finish;
      end
   end

   initial begin
      int n;
      logic sr, sf;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset read", bus_rdata, 16'h6900);
      chk("R1 reset pulse", wdt_rst, 0);
      chk("R1 reset flag", irq_flag, 0);

      for (int i = 0; i < 8; i++) begin
         wr(VEC[i][32:17]);
         chk("R2/R3 vector read", bus_rdata, VEC[i][16:1]);
         chk("R2 vector reset", wdt_rst, VEC[i][0]);
      end

      // R6 clear restarts count, R7 tap 3
      wr(16'h5A0B);
      clk_en_a = 1; run_until(30, n, sr, sf); clk_en_a = 0;
      chk("R6 no early expiry", {sr, sf}, 0);
      wr(16'h5A0B);
      clk_en_a = 1; run_until(100, n, sr, sf); clk_en_a = 0;
      chk("R6 restart count", n, 64);
      chk("R4 reset raised", sr, 1);
      chk("R4 fields default", bus_rdata, 16'h6900);
      @(negedge clk);
      chk("R4 single cycle", wdt_rst, 0);

      // R5 hold freezes, release resumes
      wr(16'h5A8B);
      clk_en_a = 1; run_until(200, n, sr, sf); clk_en_a = 0;
      chk("R5 held no expiry", {sr, sf}, 0);
      wr(16'h5A03);
      clk_en_a = 1; run_until(100, n, sr, sf); clk_en_a = 0;
      chk("R5 resume from frozen", n, 64);
      chk("R5 reset after release", sr, 1);

      // R9 select enable B; enable A also active but ignored
      wr(16'h5A0F);
      clk_en_a = 1; tb_on = 1;
      run_until(400, n, sr, sf);
      clk_en_a = 0; tb_on = 0;
      chk("R9 source B timing", (n >= 250 && n <= 260), 1);
      chk("R9 reset from source B", sr, 1);

      // R8 interval mode, tap 3
      @(negedge clk);
      wr(16'h5A1B);
      clk_en_a = 1; run_until(100, n, sr, sf);
      chk("R8 flag interval", n, 64);
      chk("R8 flag set", sf, 1);
      chk("R8 no reset", sr, 0);
      ack();
      chk("R8 ack clears flag", irq_flag, 0);
      run_until(100, n, sr, sf); clk_en_a = 0;
      chk("R8 periodic flag", n, 63);
      chk("R8 periodic no reset", sr, 0);
      ack();

      // R7 tap 2 and tap 1 in interval mode
      wr(16'h5A1A);
      clk_en_a = 1; run_until(600, n, sr, sf); clk_en_a = 0;
      chk("R7 tap 2 interval", n, 512);
      ack();
      wr(16'h5A19);
      clk_en_a = 1; run_until(9000, n, sr, sf); clk_en_a = 0;
      chk("R7 tap 1 interval", n, 8192);
      ack();

      // R4 / R7 default watchdog interval
      wr(16'h5A08);
      clk_en_a = 1; run_until(40000, n, sr, sf); clk_en_a = 0;
      chk("R7 tap 0 interval", n, 32768);
      chk("R4 watchdog reset", sr, 1);
      chk("R1 defaults after reset", bus_rdata, 16'h6900);
      chk("R1 flag clear after reset", irq_flag, 0);
      @(negedge clk);
      chk("R4 pulse ends", wdt_rst, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
   end

endmodule